// File: doc/BRIEF.md
# Scatter Segment to Descriptor Splitter

This block turns a request made of scatter segments into a table of physical-region descriptors for a bus-master storage DMA engine. Each segment has a 32-bit bus address and a byte length. Each descriptor leaves as two words: the address word first, then a control word. The splitter makes sure that no descriptor spans a 64 KiB address boundary. It counts the entries it builds and tags the final one. When the table would be too large, when the request yields no entries, or when an input is misaligned, it tells the host to fall back to programmed I/O.

Segments enter on a valid/ready handshake, and `seg_last` marks the final segment of a request. Descriptor words leave on a second valid/ready handshake. The most recent entry is held back until the block knows whether another entry follows, so that the end-of-table marking can be applied to it. After the final word has been accepted, a one-cycle `done` pulse reports the entry count, the fallback flag and the alignment error flag.

Two configuration inputs select the variants. `cfg_split64` breaks every full 64 KiB entry into two halves. `cfg_alt` selects the word-count encoding. Both inputs must stay stable while a request is in progress.

Top module: `prd_splitter`

## Requirements
- R1: Each descriptor's byte count is the smaller of the bytes left in the segment and the distance to the next 64 KiB address boundary. Descriptors appear in ascending address order.
- R2: In the default mode (`cfg_alt`=0), control word bits 15:0 hold the low 16 bits of the byte count, so 0x0000 means 65536 bytes. Bits 30:16 are zero.
- R3: When `cfg_split64`=1 in the default mode, a 65536-byte chunk at address A is emitted as two entries: 0x8000 bytes at A, then 0x8000 bytes at A+0x8000.
- R4: In the default mode, bit 31 of the control word is 1 only on the final descriptor of a successful table. `desc_eot` is high only together with that final control word, in either mode.
- R5: In the alternate mode (`cfg_alt`=1), control word bits 31:16 hold (bytes/4 − 1) and bits 15:0 are zero. No end-of-table bit is set in the word.
- R6: Each entry leaves as its address word followed by its control word. While `desc_valid` is high and `desc_ready` is low, the word and `desc_eot` hold steady.
- R7: A request that needs more than CAP entries ends with `done_fallback`=1 and `done_count`=0, and no word carries `desc_eot`. A request of exactly CAP entries succeeds.
- R8: A request whose segments all have zero length ends with `done_fallback`=1.
- R9: In the default mode, an odd address or length is misaligned. In the alternate mode, an address or length that is not a multiple of 4 is misaligned. A misaligned segment ends the request with `done_align_err`=1 and `done_fallback`=1.
- R10: `done` pulses for exactly one cycle after the final word of a request is accepted. On success, `done_count` equals the number of entries.
- R11: After reset, `seg_ready`=1, `desc_valid`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_split64 | input | 1 | Break full 64 KiB entries into two halves (default mode only) |
| cfg_alt | input | 1 | Select the alternate word-count encoding |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted on this cycle when valid is high |
| seg_addr | input | 32 | Segment bus address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | Final segment of the request |
| desc_valid | output | 1 | Descriptor word offered |
| desc_ready | input | 1 | Consumer takes the word |
| desc_word | output | 32 | Address word or control word |
| desc_eot | output | 1 | Final control word of the table |
| done | output | 1 | One-cycle request completion pulse |
| done_fallback | output | 1 | Table abandoned; use programmed I/O |
| done_align_err | output | 1 | Request held a misaligned segment |
| done_count | output | CNT_W | Entries built (0 on fallback) |

## Verification
The splitter is driven with single segments placed inside one 64 KiB window, straddling a boundary, covering one exact window, and starting halfway through a window. These separate the boundary arithmetic from the full-window encoding of 0x0000 and from the halving option. The same kinds of segment are repeated in the alternate mode, which shows whether the count transform and the absent end bit are applied to the right word. Multi-segment requests that include a zero-length segment, made under random output stalls, show that only the true final entry is tagged. Tables of exactly the capacity and of one entry beyond it, empty requests and misaligned inputs then exercise each fallback path.

// File: rtl/prd_split_pkg.sv
package prd_split_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SPLIT,
    ST_FINAL,
    ST_WAITD,
    ST_DRAIN,
    ST_FAIL
  } prd_state_e;

  // Bytes from the given window offset up to the next 64 KiB boundary.
  function automatic logic [16:0] prd_room(input logic [15:0] off);
    return 17'h10000 - {1'b0, off};
  endfunction

  // Control word for a chunk of 1..65536 bytes.
  function automatic logic [31:0] prd_ctrl(input logic [16:0] bytes,
                                           input logic alt,
                                           input logic eot);
    logic [16:0] words_m1;
    words_m1 = (bytes >> 2) - 17'd1;
    if (alt) return {words_m1[15:0], 16'h0000};
    return {eot, 15'h0000, bytes[15:0]};
  endfunction

  // Alignment rule: 2 bytes in the default mode, 4 bytes in the alternate mode.
  function automatic logic prd_misaligned(input logic [1:0] addr_lo,
                                          input logic [1:0] len_lo,
                                          input logic alt);
    if (alt) return (|addr_lo) | (|len_lo);
    return addr_lo[0] | len_lo[0];
  endfunction

endpackage

// File: rtl/prd_chunker.sv
module prd_chunker
  import prd_split_pkg::*;
#(
  parameter int LEN_W = 20
) (
  input  logic [15:0]      win_off,
  input  logic [LEN_W-1:0] rem,
  input  logic             split_en,
  input  logic             alt,
  output logic [16:0]      chunk,
  output logic             ends_seg
);

  logic [16:0] room;
  logic [16:0] fit;

  always_comb begin
    room = prd_room(win_off);
    fit  = (rem >= LEN_W'(room)) ? room : rem[16:0];
    if (split_en && !alt && fit == 17'h10000) chunk = 17'h08000;
    else                                      chunk = fit;
    ends_seg = (rem == LEN_W'(chunk));
  end

endmodule

// File: rtl/prd_word_tx.sv
module prd_word_tx (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  logic [31:0] l_addr,
  input  logic [31:0] l_ctrl,
  input  logic        l_eot,
  output logic        idle,
  output logic        o_valid,
  input  logic        o_ready,
  output logic [31:0] o_word,
  output logic        o_eot
);

  logic [1:0]  phase;
  logic [31:0] addr_q;
  logic [31:0] ctrl_q;
  logic        eot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= 2'd0;
      addr_q <= '0;
      ctrl_q <= '0;
      eot_q  <= 1'b0;
    end else begin
      case (phase)
        2'd0: if (launch) begin
          addr_q <= l_addr;
          ctrl_q <= l_ctrl;
          eot_q  <= l_eot;
          phase  <= 2'd1;
        end
        2'd1: if (o_ready) phase <= 2'd2;
        default: if (o_ready) phase <= 2'd0;
      endcase
    end
  end

  assign idle    = (phase == 2'd0);
  assign o_valid = !idle;
  assign o_word  = (phase == 2'd1) ? addr_q : ctrl_q;
  assign o_eot   = (phase == 2'd2) && eot_q;

endmodule

// File: rtl/prd_splitter.sv
module prd_splitter
  import prd_split_pkg::*;
#(
  parameter  int LEN_W = 20,
  parameter  int CAP   = 256,
  localparam int CNT_W = $clog2(CAP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_split64,
  input  logic             cfg_alt,
  input  logic             seg_valid,
  output logic             seg_ready,
  input  logic [31:0]      seg_addr,
  input  logic [LEN_W-1:0] seg_len,
  input  logic             seg_last,
  output logic             desc_valid,
  input  logic             desc_ready,
  output logic [31:0]      desc_word,
  output logic             desc_eot,
  output logic             done,
  output logic             done_fallback,
  output logic             done_align_err,
  output logic [CNT_W-1:0] done_count
);

  prd_state_e       st;
  logic [31:0]      cur_addr;
  logic [LEN_W-1:0] cur_rem;
  logic             last_q;
  logic             pend_vld;
  logic [31:0]      pend_addr;
  logic [16:0]      pend_bytes;
  logic [CNT_W-1:0] cnt;
  logic             align_q;

  // Named internal events, used by the checker.
  logic             seg_fire;
  logic             seg_bad;
  logic             at_cap;
  logic             ent_load;
  logic             launch;
  logic             launch_eot;
  logic [31:0]      launch_ctrl;
  logic [16:0]      chunk;
  logic             ends_seg;
  logic             tx_idle;

  prd_chunker #(.LEN_W(LEN_W)) u_chunk (
    .win_off  (cur_addr[15:0]),
    .rem      (cur_rem),
    .split_en (cfg_split64),
    .alt      (cfg_alt),
    .chunk    (chunk),
    .ends_seg (ends_seg)
  );

  always_comb begin
    seg_ready   = (st == ST_IDLE) || (st == ST_DRAIN);
    seg_fire    = seg_valid && seg_ready;
    seg_bad     = prd_misaligned(seg_addr[1:0], seg_len[1:0], cfg_alt);
    at_cap      = (cnt == CNT_W'(CAP));
    ent_load    = (st == ST_SPLIT) && !at_cap && (!pend_vld || tx_idle);
    launch_eot  = (st == ST_FINAL);
    launch      = (ent_load && pend_vld) || (launch_eot && tx_idle && pend_vld);
    launch_ctrl = prd_ctrl(pend_bytes, cfg_alt, launch_eot && !cfg_alt);
  end

  prd_word_tx u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (launch),
    .l_addr  (pend_addr),
    .l_ctrl  (launch_ctrl),
    .l_eot   (launch_eot),
    .idle    (tx_idle),
    .o_valid (desc_valid),
    .o_ready (desc_ready),
    .o_word  (desc_word),
    .o_eot   (desc_eot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= ST_IDLE;
      cur_addr       <= '0;
      cur_rem        <= '0;
      last_q         <= 1'b0;
      pend_vld       <= 1'b0;
      pend_addr      <= '0;
      pend_bytes     <= '0;
      cnt            <= '0;
      align_q        <= 1'b0;
      done           <= 1'b0;
      done_fallback  <= 1'b0;
      done_align_err <= 1'b0;
      done_count     <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (seg_fire) begin
          if (seg_bad) begin
            align_q  <= 1'b1;
            pend_vld <= 1'b0;
            st       <= seg_last ? ST_FAIL : ST_DRAIN;
          end else begin
            cur_addr <= seg_addr;
            cur_rem  <= seg_len;
            last_q   <= seg_last;
            if (seg_len == '0) st <= seg_last ? ST_FINAL : ST_IDLE;
            else               st <= ST_SPLIT;
          end
        end
        ST_SPLIT: begin
          if (at_cap) begin
            pend_vld <= 1'b0;
            st       <= last_q ? ST_FAIL : ST_DRAIN;
          end else if (ent_load) begin
            pend_addr  <= cur_addr;
            pend_bytes <= chunk;
            pend_vld   <= 1'b1;
            cnt        <= cnt + 1'b1;
            cur_addr   <= cur_addr + {15'd0, chunk};
            cur_rem    <= cur_rem - LEN_W'(chunk);
            if (ends_seg) st <= last_q ? ST_FINAL : ST_IDLE;
          end
        end
        ST_FINAL: if (tx_idle) begin
          if (pend_vld) begin
            pend_vld <= 1'b0;
            st       <= ST_WAITD;
          end else begin
            st <= ST_FAIL;
          end
        end
        ST_WAITD: if (tx_idle) begin
          done           <= 1'b1;
          done_fallback  <= 1'b0;
          done_align_err <= 1'b0;
          done_count     <= cnt;
          cnt            <= '0;
          st             <= ST_IDLE;
        end
        ST_DRAIN: if (seg_fire) begin
          if (seg_bad) align_q <= 1'b1;
          if (seg_last) st <= ST_FAIL;
        end
        ST_FAIL: if (tx_idle) begin
          done           <= 1'b1;
          done_fallback  <= 1'b1;
          done_align_err <= align_q;
          done_count     <= '0;
          cnt            <= '0;
          align_q        <= 1'b0;
          pend_vld       <= 1'b0;
          st             <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/prd_splitter_chk.sv
module prd_splitter_chk #(
  parameter int CAP   = 256,
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_split64,
  input logic             cfg_alt,
  input logic             desc_valid,
  input logic             desc_ready,
  input logic [31:0]      desc_word,
  input logic             desc_eot,
  input logic             done,
  input logic             done_fallback,
  input logic [CNT_W-1:0] done_count,
  input logic             ent_load,
  input logic [15:0]      ent_off,
  input logic [16:0]      ent_bytes,
  input logic [CNT_W-1:0] cnt
);

  assert_no_cross_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ent_load |-> (ent_bytes != 17'd0) && (({2'b00, ent_off} + {1'b0, ent_bytes}) <= 18'h10000));

  assert_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ent_load && cfg_split64 && !cfg_alt |-> ent_bytes <= 17'h08000);

  assert_eot_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    desc_eot |-> desc_valid && (cfg_alt || desc_word[31]));

  assert_alt_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    desc_eot && cfg_alt |-> desc_word[15:0] == 16'h0000);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_word) && $stable(desc_eot));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(CAP));

  assert_fb_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_fallback |-> done_count == '0);

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind prd_splitter prd_splitter_chk #(.CAP(CAP), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_split64   (cfg_split64),
  .cfg_alt       (cfg_alt),
  .desc_valid    (desc_valid),
  .desc_ready    (desc_ready),
  .desc_word     (desc_word),
  .desc_eot      (desc_eot),
  .done          (done),
  .done_fallback (done_fallback),
  .done_count    (done_count),
  .ent_load      (ent_load),
  .ent_off       (cur_addr[15:0]),
  .ent_bytes     (chunk),
  .cnt           (cnt)
);

// File: tb/prd_splitter_bench.sv
module prd_splitter_bench;

  localparam int LEN_W = 20;
  localparam int CAP   = 6;
  localparam int CNT_W = $clog2(CAP + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_split64 = 1'b0;
  logic             cfg_alt = 1'b0;
  logic             seg_valid = 1'b0;
  logic             seg_ready;
  logic [31:0]      seg_addr = '0;
  logic [LEN_W-1:0] seg_len = '0;
  logic             seg_last = 1'b0;
  logic             desc_valid;
  logic             desc_ready = 1'b1;
  logic [31:0]      desc_word;
  logic             desc_eot;
  logic             done;
  logic             done_fallback;
  logic             done_align_err;
  logic [CNT_W-1:0] done_count;

  always #4 clk = ~clk;

  prd_splitter #(.LEN_W(LEN_W), .CAP(CAP)) u_prd_splitter (.*);

  int checks = 0;
  int fails  = 0;
  bit stall_en = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  always @(posedge clk) desc_ready <= stall_en ? (($urandom % 4) != 0) : 1'b1;

  // Expected table model
  logic [31:0] ent_a [0:31];
  int          ent_b [0:31];
  int          ent_n = 0;
  logic [31:0] exp_w [0:63];
  bit          exp_e [0:63];
  int          exp_n = 0;
  int          rx_n = 0;
  int          eot_seen = 0;
  bit          cmp_en = 1'b0;
  string       cur_tag = "R1";
  bit          got_done = 1'b0;
  int          d_cnt = 0;
  bit          d_fb = 1'b0;
  bit          d_al = 1'b0;

  task automatic push_ent(input logic [31:0] a, input int b);
    if (ent_n < 32) begin
      ent_a[ent_n] = a;
      ent_b[ent_n] = b;
    end
    ent_n++;
  endtask

  task automatic model_seg(input logic [31:0] a0, input int n0, input bit sp, input bit al);
    logic [31:0] a;
    int n;
    int room;
    int c;
    a = a0;
    n = n0;
    while (n > 0) begin
      room = 65536 - int'(a[15:0]);
      c = (n < room) ? n : room;
      if (sp && !al && c == 65536) begin
        push_ent(a, 32768);
        push_ent(a + 32'h8000, 32768);
      end else begin
        push_ent(a, c);
      end
      a = a + 32'(c);
      n = n - c;
    end
  endtask

  task automatic build_exp(input bit al);
    exp_n = 0;
    for (int i = 0; i < ent_n && i < 32; i++) begin
      logic [31:0] cw;
      bit fin;
      fin = (i == ent_n - 1);
      if (al) cw = 32'((ent_b[i] / 4) - 1) << 16;
      else    cw = {fin, 15'h0, 16'(ent_b[i] % 65536)};
      exp_w[exp_n] = ent_a[i];
      exp_e[exp_n] = 1'b0;
      exp_w[exp_n + 1] = cw;
      exp_e[exp_n + 1] = fin;
      exp_n += 2;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && desc_valid && desc_ready) begin
      if (desc_eot) eot_seen++;
      if (cmp_en) begin
        if (rx_n < exp_n)
          chk(desc_word == exp_w[rx_n] && desc_eot == exp_e[rx_n], cur_tag,
              {desc_word[31:1], desc_eot}, {exp_w[rx_n][31:1], exp_e[rx_n]});
        else
          chk(1'b0, "R6", desc_word, 32'h0);
      end
      rx_n++;
    end
    if (rst_n && done) begin
      got_done = 1'b1;
      d_cnt    = int'(done_count);
      d_fb     = done_fallback;
      d_al     = done_align_err;
    end
  end

  task automatic send(input logic [31:0] a, input int n, input bit last);
    @(negedge clk);
    seg_valid = 1'b1;
    seg_addr  = a;
    seg_len   = LEN_W'(n);
    seg_last  = last;
    while (!seg_ready) @(negedge clk);
    @(negedge clk);
    seg_valid = 1'b0;
    seg_last  = 1'b0;
  endtask

  task automatic finish_req(input bit exp_fb, input bit exp_al, input string tag);
    int waited;
    waited = 0;
    while (!got_done && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    chk(got_done, "R10", 32'(got_done), 32'd1);
    chk(d_fb == exp_fb, tag, 32'(d_fb), 32'(exp_fb));
    chk(d_al == exp_al, "R9", 32'(d_al), 32'(exp_al));
    if (exp_fb) begin
      chk(eot_seen == 0, "R7", 32'(eot_seen), 32'd0);
      chk(d_cnt == 0, "R7", 32'(d_cnt), 32'd0);
    end else begin
      chk(d_cnt == ent_n, "R10", 32'(d_cnt), 32'(ent_n));
      chk(rx_n == exp_n, "R6", 32'(rx_n), 32'(exp_n));
      chk(eot_seen == 1, "R4", 32'(eot_seen), 32'd1);
    end
    @(negedge clk);
    chk(!done, "R10", 32'(done), 32'd0);
    got_done = 1'b0;
    rx_n = 0;
    eot_seen = 0;
    ent_n = 0;
    exp_n = 0;
  endtask

  // {addr, len, split64, alt}
  localparam int NV = 8;
  localparam logic [53:0] VEC [0:NV-1] = '{
    {32'h0000_1000, 20'h00200, 1'b0, 1'b0},
    {32'h0001_F000, 20'h02000, 1'b0, 1'b0},
    {32'h0002_0000, 20'h10000, 1'b0, 1'b0},
    {32'h0002_0000, 20'h10000, 1'b1, 1'b0},
    {32'h0003_8000, 20'h18000, 1'b1, 1'b0},
    {32'h0004_0000, 20'h10000, 1'b0, 1'b1},
    {32'h0005_FFF0, 20'h00020, 1'b0, 1'b1},
    {32'h0000_0002, 20'h0000E, 1'b0, 1'b0}
  };

  bit finished = 1'b0;

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(seg_ready == 1'b1, "R11", 32'(seg_ready), 32'd1);
    chk(desc_valid == 1'b0, "R11", 32'(desc_valid), 32'd0);
    chk(done == 1'b0, "R11", 32'(done), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk: single-segment requests in both modes
    for (int v = 0; v < NV; v++) begin
      cfg_split64 = VEC[v][1];
      cfg_alt     = VEC[v][0];
      stall_en    = v[0];
      model_seg(VEC[v][53:22], int'(VEC[v][21:2]), VEC[v][1], VEC[v][0]);
      build_exp(VEC[v][0]);
      cur_tag = "R1/R2/R3/R5";
      cmp_en  = 1'b1;
      send(VEC[v][53:22], int'(VEC[v][21:2]), 1'b1);
      finish_req(1'b0, 1'b0, "R10");
    end

    // Multi-segment with a zero-length segment, random stalls: only last tagged (R4)
    cfg_split64 = 1'b0;
    cfg_alt     = 1'b0;
    stall_en    = 1'b1;
    model_seg(32'h0000_1000, 32'h100, 1'b0, 1'b0);
    model_seg(32'h0000_2000, 0, 1'b0, 1'b0);
    model_seg(32'h3000_FF00, 32'h200, 1'b0, 1'b0);
    build_exp(1'b0);
    cur_tag = "R4";
    send(32'h0000_1000, 32'h100, 1'b0);
    send(32'h0000_2000, 0, 1'b0);
    send(32'h3000_FF00, 32'h200, 1'b1);
    finish_req(1'b0, 1'b0, "R4");

    // Exactly CAP entries succeeds (R7)
    stall_en = 1'b0;
    model_seg(32'h0010_0000, 32'h60000, 1'b0, 1'b0);
    build_exp(1'b0);
    cur_tag = "R7";
    send(32'h0010_0000, 32'h60000, 1'b1);
    finish_req(1'b0, 1'b0, "R7");

    // CAP+1 entries in one segment: fallback (R7)
    cmp_en = 1'b0;
    send(32'h0010_0000, 32'h70000, 1'b1);
    finish_req(1'b1, 1'b0, "R7");

    // Overflow followed by further segments: drained, fallback (R7)
    send(32'h0020_0000, 32'h70000, 1'b0);
    send(32'h0030_0000, 32'h100, 1'b1);
    finish_req(1'b1, 1'b0, "R7");

    // Overflow from halving: 4 full windows give 8 entries > CAP (R3, R7)
    cfg_split64 = 1'b1;
    send(32'h0040_0000, 32'h40000, 1'b1);
    finish_req(1'b1, 1'b0, "R7");
    cfg_split64 = 1'b0;

    // Zero-entry request (R8)
    send(32'h0000_4000, 0, 1'b0);
    send(32'h0000_5000, 0, 1'b1);
    finish_req(1'b1, 1'b0, "R8");

    // Misaligned address in default mode (R9)
    send(32'h0000_1001, 32'h10, 1'b1);
    finish_req(1'b1, 1'b1, "R9");

    // Length not a multiple of 4 in alternate mode, on a later segment (R9)
    cfg_alt = 1'b1;
    send(32'h0000_2000, 32'h10, 1'b0);
    send(32'h0000_3000, 32'h6, 1'b1);
    finish_req(1'b1, 1'b1, "R9");

    // Recovery: a clean alternate-mode request after errors (R5)
    cmp_en = 1'b1;
    model_seg(32'h0006_FFFC, 32'h8, 1'b0, 1'b1);
    build_exp(1'b1);
    cur_tag = "R5";
    send(32'h0006_FFFC, 32'h8, 1'b1);
    finish_req(1'b0, 1'b0, "R5");

    report();
  end

endmodule